// File: doc/BRIEF.md
# Bootstrap Capacitor Refresh Controller

This block keeps the high-side bootstrap capacitor of a synchronous buck power stage charged during long idle spells. Two comparator flags arrive already digitized. One says the capacitor voltage has sagged below a lower threshold. The other says it has climbed above an upper threshold.

When the lower flag is seen, the controller enters a charging episode. It stays there until the upper flag appears. While charging, it drives a repeating train of fixed low-side pulses: `ON_CYCLES` clock cycles high, then `OFF_CYCLES` cycles low. The low time lets the inductor current decay back to zero before the next pulse. The output is meant to be ORed into the low-side gate request.

A qualified PWM command at a firm high or low level always wins over a refresh pulse. So does the driver enable going low. In either case the output drops in the same cycle and the pulse phase restarts. Supply undervoltage forces the output low and abandons the episode.

Top module: `boot_refresh_ctrl`

## Requirements
- R1: After reset the refresh output is low. It stays low for as long as `boot_low` has not been seen, whatever the command.
- R2: While the controller is monitoring, `boot_low` sampled high at a clock edge, with `uv_supply` and `boot_high` low, starts an episode. If the command is idle (`pwm_cmd[1]`=1) and `en`=1, `refresh_gl` goes high in the cycle right after that edge.
- R3: During an episode with idle command and `en`=1, `refresh_gl` repeats a fixed pattern. It is high for `ON_CYCLES` cycles, then low for `OFF_CYCLES` cycles, and this continues until the episode ends.
- R4: `boot_high` sampled high at an edge ends the episode. `refresh_gl` is low from the next cycle on and stays low until `boot_low` is seen again.
- R5: A non-idle command forces `refresh_gl` low in the same cycle. The command encoding is `pwm_cmd`=2'b00 for a firm low level and 2'b01 for a firm high level. Once the command returns to idle, the pattern restarts with a full `ON_CYCLES` high phase.
- R6: `en`=0 forces `refresh_gl` low in the same cycle. Once `en` returns to 1, the pattern restarts with a full `ON_CYCLES` high phase.
- R7: `uv_supply`=1 forces `refresh_gl` low in the same cycle and abandons the episode. After the undervoltage clears, no pulse is issued until `boot_low` is seen again. `boot_low` during undervoltage is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Driver enable; refresh is allowed only while high |
| uv_supply | input | 1 | Supply undervoltage flag |
| boot_low | input | 1 | Boot capacitor voltage below lower threshold |
| boot_high | input | 1 | Boot capacitor voltage above upper threshold |
| pwm_cmd | input | 2 | Qualified command: 00 low, 01 high, 1x idle |
| refresh_gl | output | 1 | Low-side gate refresh request |

## Verification
The hardest case to reach is an override that lands on one exact phase of the pulse train. An overlap at the last high cycle, or in the middle of the low gap, is what exposes a phase counter that fails to restart.

The stimulus starts a fresh episode for every offset within one period. At that offset it applies a one-cycle active command, or a one-cycle enable drop. It then checks a whole period afterwards against the arithmetic pattern (t mod period) < ON. The same per-offset sweep is used for the stop flag.

// File: rtl/boot_refresh_ctrl.sv
module boot_refresh_ctrl #(
  parameter int ON_CYCLES  = 20,
  parameter int OFF_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       uv_supply,
  input  logic       boot_low,
  input  logic       boot_high,
  input  logic [1:0] pwm_cmd,
  output logic       refresh_gl
);
  localparam int MAXC = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYCLES - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYCLES - 1);

  typedef enum logic [1:0] {ST_MON, ST_ON, ST_OFF} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          idle;
  logic          allow;

  assign idle  = pwm_cmd[1];
  assign allow = idle & en & ~uv_supply;
  assign refresh_gl = (state == ST_ON) & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_MON;
      cnt   <= '0;
    end else if (uv_supply || boot_high) begin
      state <= ST_MON;
      cnt   <= '0;
    end else if (state == ST_MON) begin
      if (boot_low) state <= ST_ON;
      cnt <= '0;
    end else if (!allow) begin
      state <= ST_ON;
      cnt   <= '0;
    end else if (state == ST_ON) begin
      if (cnt == ON_LAST) begin
        state <= ST_OFF;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == OFF_LAST) begin
        state <= ST_ON;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_STOP_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    boot_high |=> !refresh_gl); // R4
  AST_UV_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    uv_supply |=> (state == ST_MON)); // R7
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (cnt == '0)); // R5
  AST_START_EPISODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MON && boot_low && !boot_high && !uv_supply) |=> (state == ST_ON)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ON) |-> (cnt <= ON_LAST)); // R3
endmodule

// File: tb/test_boot_refresh_ctrl.sv
module test_boot_refresh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ON  = 4;
  localparam int OFF = 3;
  localparam int P   = ON + OFF;

  logic clk = 0, rst_n = 0, en = 1, uv_supply = 0, boot_low = 0, boot_high = 0;
  logic [1:0] pwm_cmd = 2'b10;
  logic refresh_gl;
  int errors = 0, checks = 0;

  boot_refresh_ctrl #(.ON_CYCLES(ON), .OFF_CYCLES(OFF)) i_boot_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .uv_supply(uv_supply),
    .boot_low(boot_low), .boot_high(boot_high), .pwm_cmd(pwm_cmd),
    .refresh_gl(refresh_gl));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic exp);
    checks++;
    if (refresh_gl !== exp) begin
      errors++;
      $display("FAIL %s at %0t: refresh_gl=%b expected %b", req, $time, refresh_gl, exp);
    end
  endtask

  task automatic edge_drive();
    @(posedge clk); #2;
  endtask

  task automatic start_refresh();
    edge_drive(); boot_high = 1; boot_low = 0;
    edge_drive(); boot_high = 0; boot_low = 1;
    edge_drive(); boot_low = 0;
  endtask

  task automatic sweep(input string req, input int n);
    for (int t = 0; t < n; t++) begin
      if (t > 0) edge_drive();
      #3; chk(req, (t % P) < ON);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3; chk("R1", 0);
    repeat (3) edge_drive();
    rst_n = 1;
    for (int i = 0; i < 2 * P; i++) begin
      pwm_cmd = (i % 3 == 0) ? 2'b00 : ((i % 3 == 1) ? 2'b01 : 2'b11);
      #3; chk("R1", 0); edge_drive();
    end
    pwm_cmd = 2'b10;

    start_refresh(); #3; chk("R2", 1);
    for (int t = 1; t < 3 * P; t++) begin edge_drive(); #3; chk("R3", (t % P) < ON); end

    for (int k = 0; k < P; k++) begin
      start_refresh();
      sweep("R3", k);
      if (k > 0) edge_drive();
      pwm_cmd = k[0] ? 2'b01 : 2'b00;
      #3; chk("R5", 0);
      edge_drive(); pwm_cmd = 2'b10;
      sweep("R5", P + 1);
    end

    for (int k = 0; k < P; k++) begin
      start_refresh();
      sweep("R3", k);
      if (k > 0) edge_drive();
      en = 0;
      #3; chk("R6", 0);
      edge_drive(); en = 1;
      sweep("R6", P + 1);
    end

    for (int k = 0; k < P; k++) begin
      start_refresh();
      sweep("R3", k);
      if (k > 0) edge_drive();
      boot_high = 1;
      edge_drive(); boot_high = 0;
      for (int j = 0; j < P; j++) begin
        if (j > 0) edge_drive();
        #3; chk("R4", 0);
      end
    end

    start_refresh();
    sweep("R3", 2);
    edge_drive(); uv_supply = 1;
    #3; chk("R7", 0);
    edge_drive(); uv_supply = 0;
    for (int j = 0; j < 2 * P; j++) begin
      if (j > 0) edge_drive();
      #3; chk("R7", 0);
    end
    edge_drive(); uv_supply = 1; boot_low = 1;
    for (int j = 0; j < 3; j++) begin
      if (j > 0) edge_drive();
      #3; chk("R7", 0);
    end
    edge_drive(); uv_supply = 0; boot_low = 0;
    for (int j = 0; j < 2 * P; j++) begin
      if (j > 0) edge_drive();
      #3; chk("R7", 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule